// File: doc/BRIEF.md
# Single-Frame Packet Mailbox

This block connects a processor to an Ethernet MAC without DMA. The processor moves frame data itself through 32-bit register windows. The block holds exactly one transmit frame and one receive frame. For each direction, a single ownership bit passes that frame between software and hardware. There are no descriptors and no queue.

To send, software pushes big-endian words through the transmit window and then writes the byte count with the ready bit set. The block then streams the bytes to the MAC, one byte per accepted beat. When the last byte is accepted it clears the ready bit, reports any MAC error and raises the transmit-done cause.

On receive, the block stores an incoming byte stream, sets the receive-ready bit and records the length and the error flags. Software reads the frame through the receive window and then clears the ready bit to hand the buffer back. A frame that arrives while the buffer is still owned by software is discarded, and a sticky overflow flag is set.

Top module: `pkt_mailbox`

## Requirements
- R1: After reset, both control registers, the interrupt enable and cause registers and `irq` read as zero, and `tx_valid` is low.
- R2: A transmit frame of N bytes appears on `tx_data` as exactly N accepted beats. Within each buffered word the byte in bits [31:24] goes first (big-endian). `tx_last` is high only on the Nth beat, and data holds steady while `tx_ready` is low.
- R3: Transmit control (offset 0x800) has length in [10:0], error at bit 14 and ready at bit 15. Hardware clears ready once the last byte is accepted. The error bit then shows whether `tx_err_in` was high on any accepted beat of that frame. Starting a new frame clears the error bit.
- R4: While transmit ready is set, writes to the transmit control register and to the transmit window (offset 0x808) have no effect.
- R5: A transmit start with length 0 sends no bytes and completes at once, clearing ready and setting the transmit-done cause.
- R6: A received frame sets receive ready (bit 15 of offset 0x810) and loads its byte count into [10:0]. Reads of the window at offset 0x818 return the frame as big-endian words, starting from the first word, with unused low bytes of the final word reading as zero.
- R7: Receive error (bit 14) and CRC error (bit 13) take the values of `rx_err` and `rx_crc_err` on the last beat of the stored frame.
- R8: A frame whose first byte arrives while receive ready is set is discarded entirely: the buffer and the length are unchanged. Overflow (bit 12) is set and stays set until software writes 1 to bit 12.
- R9: Software can clear receive ready but cannot set it: writing 1 to bit 15 has no effect.
- R10: The cause register (0x8C4) has bit 0 for receive-ready and bit 1 for transmit-done. Cause bits are set by their events and cleared by writing 1. `irq`, one cycle later, is the OR of cause AND enable (0x8C0, same bit positions).
- R11: Each window has its own word pointer that advances on every access and restarts at word 0 whenever the matching ready bit changes.
- R12: Bits [31:16] of every register read as zero, and reads of any other offset, including the transmit window, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 12 | Byte offset of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| tx_ready | input | 1 | MAC accepts the transmit byte |
| tx_err_in | input | 1 | MAC transmit error, sampled on accepted beats |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the receive frame |
| rx_err | input | 1 | Receive error, sampled on the last beat |
| rx_crc_err | input | 1 | CRC error, sampled on the last beat |

## Verification
The bench stalls `tx_ready` on every other cycle. A design that advanced its byte index on a stall, or fetched the next word too early, would skip or repeat bytes at word boundaries. A second frame is arriving while receive ready is still set, and the check looks for unchanged buffer contents, an unchanged length and a sticky overflow flag. A design that overwrote the buffer or lost the flag would fail that check. Zero-length transmit, writes made while transmit is busy, and an attempt to set receive ready from software are each checked at the ports, as is the restart of the window pointer after each handoff. A missing pointer reset would send stale words.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 11;

  localparam logic [ADDR_W-1:0] A_TX_CTL    = 12'h800;
  localparam logic [ADDR_W-1:0] A_TX_WIN    = 12'h808;
  localparam logic [ADDR_W-1:0] A_RX_CTL    = 12'h810;
  localparam logic [ADDR_W-1:0] A_RX_WIN    = 12'h818;
  localparam logic [ADDR_W-1:0] A_IRQ_EN    = 12'h8C0;
  localparam logic [ADDR_W-1:0] A_IRQ_CAUSE = 12'h8C4;

  localparam int B_RDY = 15;
  localparam int B_ERR = 14;
  localparam int B_CRC = 13;
  localparam int B_OVF = 12;

  localparam int IRQ_RX = 0;
  localparam int IRQ_TX = 1;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_st_e;
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_tx_engine.sv
module mbx_tx_engine
  import mbx_pkg::*;
#(
  parameter int WORDS = 512,
  localparam int PW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic [PW-1:0]    rd_addr,
  input  logic [31:0]      rd_word,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready,
  input  logic             tx_err_in,
  output logic             done,
  output logic             err_out
);
  tx_st_e           st;
  logic [LEN_W-1:0] cnt, len_q;
  logic             err_acc;
  logic [1:0]       lane;

  assign lane     = cnt[1:0];
  assign rd_addr  = PW'(cnt >> 2);
  assign tx_valid = (st == TX_SEND);
  assign tx_data  = rd_word[8*(3-int'(lane)) +: 8];
  assign tx_last  = tx_valid && (cnt == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TX_IDLE; cnt <= '0; len_q <= '0;
      err_acc <= 1'b0; done <= 1'b0; err_out <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: if (start) begin
          cnt <= '0; len_q <= len; err_acc <= 1'b0;
          if (len == '0) begin
            done <= 1'b1; err_out <= 1'b0;
          end else st <= TX_WAIT;
        end
        TX_WAIT: st <= TX_SEND;
        TX_SEND: if (tx_ready) begin
          err_acc <= err_acc | tx_err_in;
          if (tx_last) begin
            done <= 1'b1; err_out <= err_acc | tx_err_in; st <= TX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (lane == 2'd3) st <= TX_WAIT;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R2: a byte offered and not taken stays on the bus unchanged
  a_r2_hold_data: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R3: completion is a single-cycle event
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/mbx_rx_engine.sv
module mbx_rx_engine
  import mbx_pkg::*;
#(
  parameter int WORDS = 512,
  localparam int PW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             rx_err,
  input  logic             rx_crc_err,
  output logic             we,
  output logic [PW-1:0]    waddr,
  output logic [31:0]      wdata,
  output logic             done,
  output logic [LEN_W-1:0] len,
  output logic             err,
  output logic             crc,
  output logic             ovf
);
  logic [LEN_W-1:0] cnt;
  logic             in_frame, dropping;
  logic [31:0]      asm_q, asm_nx;
  logic [1:0]       lane;
  logic             busy_eff;

  assign lane     = cnt[1:0];
  assign busy_eff = busy | done;

  always_comb begin
    asm_nx = asm_q;
    asm_nx[8*(3-int'(lane)) +: 8] = rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; in_frame <= 1'b0; dropping <= 1'b0; asm_q <= '0;
      we <= 1'b0; waddr <= '0; wdata <= '0; done <= 1'b0;
      len <= '0; err <= 1'b0; crc <= 1'b0; ovf <= 1'b0;
    end else begin
      we <= 1'b0; done <= 1'b0; ovf <= 1'b0;
      if (rx_valid) begin
        if (in_frame ? dropping : busy_eff) begin
          if (!in_frame) ovf <= 1'b1;
          in_frame <= !rx_last;
          dropping <= !rx_last;
        end else begin
          in_frame <= !rx_last;
          if (lane == 2'd3 || rx_last) begin
            we <= 1'b1; waddr <= PW'(cnt >> 2); wdata <= asm_nx; asm_q <= '0;
          end else asm_q <= asm_nx;
          if (rx_last) begin
            done <= 1'b1; len <= cnt + 1'b1; err <= rx_err; crc <= rx_crc_err;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8: nothing is written into the buffer while software owns it
  a_r8_no_store_when_owned: assert property (@(posedge clk) disable iff (rst)
    we |-> !busy);
  // R6: two completions can never be back to back
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
  import mbx_pkg::*;
#(
  parameter int BUF_WORDS = 512,
  localparam int PW = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              irq,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              tx_err_in,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  input  logic              rx_crc_err
);
  logic             tx_rdy, tx_err;
  logic [LEN_W-1:0] tx_len;
  logic             rx_rdy, rx_er, rx_crc, rx_ovf;
  logic [LEN_W-1:0] rx_len;
  logic [1:0]       irq_en, cause;
  logic [PW-1:0]    tx_ptr, rx_ptr;

  logic             tx_start, tx_done, tx_eng_err, tx_win_wr;
  logic [PW-1:0]    tx_raddr;
  logic [31:0]      tx_rword;
  logic             rx_we, rx_done, rx_eng_err, rx_eng_crc, rx_ovf_ev, rx_win_rd;
  logic [PW-1:0]    rx_waddr;
  logic [31:0]      rx_wdata, rx_rword;
  logic [LEN_W-1:0] rx_eng_len;
  logic             wr_txc, wr_rxc, rx_clear;
  logic [31:0]      reg_q;
  logic             rd_win_q;

  assign wr_txc    = host_wr && host_addr == A_TX_CTL;
  assign wr_rxc    = host_wr && host_addr == A_RX_CTL;
  assign tx_start  = wr_txc && !tx_rdy && host_wdata[B_RDY];
  assign tx_win_wr = host_wr && host_addr == A_TX_WIN && !tx_rdy;
  assign rx_win_rd = host_rd && host_addr == A_RX_WIN;
  assign rx_clear  = wr_rxc && rx_rdy && !host_wdata[B_RDY];

  mbx_ram #(.DEPTH(BUF_WORDS), .WIDTH(32)) u_tx_ram (
    .clk(clk), .we(tx_win_wr), .waddr(tx_ptr), .wdata(host_wdata),
    .re(1'b1), .raddr(tx_raddr), .rdata(tx_rword));

  mbx_tx_engine #(.WORDS(BUF_WORDS)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .len(host_wdata[LEN_W-1:0]),
    .rd_addr(tx_raddr), .rd_word(tx_rword), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_err_in(tx_err_in), .done(tx_done), .err_out(tx_eng_err));

  mbx_ram #(.DEPTH(BUF_WORDS), .WIDTH(32)) u_rx_ram (
    .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
    .re(rx_win_rd), .raddr(rx_ptr), .rdata(rx_rword));

  mbx_rx_engine #(.WORDS(BUF_WORDS)) u_rx (
    .clk(clk), .rst(rst), .busy(rx_rdy), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .rx_crc_err(rx_crc_err), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
    .done(rx_done), .len(rx_eng_len), .err(rx_eng_err), .crc(rx_eng_crc),
    .ovf(rx_ovf_ev));

  // control and interrupt state
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_rdy <= 1'b0; tx_err <= 1'b0; tx_len <= '0; tx_ptr <= '0;
      rx_rdy <= 1'b0; rx_er <= 1'b0; rx_crc <= 1'b0; rx_ovf <= 1'b0;
      rx_len <= '0; rx_ptr <= '0; irq_en <= '0; cause <= '0; irq <= 1'b0;
    end else begin
      if (tx_start) begin
        tx_rdy <= 1'b1; tx_len <= host_wdata[LEN_W-1:0]; tx_err <= 1'b0;
      end else if (tx_done) begin
        tx_rdy <= 1'b0; tx_err <= tx_eng_err;
      end
      if (tx_start || tx_done) tx_ptr <= '0;
      else if (tx_win_wr) tx_ptr <= tx_ptr + 1'b1;

      if (rx_done) begin
        rx_rdy <= 1'b1; rx_len <= rx_eng_len; rx_er <= rx_eng_err; rx_crc <= rx_eng_crc;
      end else if (rx_clear) rx_rdy <= 1'b0;
      if (rx_ovf_ev) rx_ovf <= 1'b1;
      else if (wr_rxc && host_wdata[B_OVF]) rx_ovf <= 1'b0;
      if (rx_done || rx_clear) rx_ptr <= '0;
      else if (rx_win_rd) rx_ptr <= rx_ptr + 1'b1;

      if (host_wr && host_addr == A_IRQ_EN) irq_en <= host_wdata[1:0];
      cause <= (cause & ~((host_wr && host_addr == A_IRQ_CAUSE) ? host_wdata[1:0] : 2'b00))
             | {tx_done, rx_done};
      irq <= |(cause & irq_en);
    end
  end

  // host read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0; rd_win_q <= 1'b0; host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      rd_win_q    <= rx_win_rd;
      reg_q       <= '0;
      if (host_rd) begin
        case (host_addr)
          A_TX_CTL:    reg_q <= {16'h0, tx_rdy, tx_err, 3'b000, tx_len};
          A_RX_CTL:    reg_q <= {16'h0, rx_rdy, rx_er, rx_crc, rx_ovf, 1'b0, rx_len};
          A_IRQ_EN:    reg_q <= {30'h0, irq_en};
          A_IRQ_CAUSE: reg_q <= {30'h0, cause};
          default:     reg_q <= '0;
        endcase
      end
    end
  end
  assign host_rdata = rd_win_q ? rx_rword : reg_q;

  // R4: transmit ownership passes to hardware only on a control write
  a_r4_tx_rdy_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_rdy) |-> $past(wr_txc));
  // R9: receive ownership returns to hardware only on a control write
  a_r9_rx_rdy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_rdy) |-> $past(wr_rxc));
  // R8: overflow can only appear while software owns the receive buffer
  a_r8_ovf_when_owned: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf) |-> $past(rx_rdy));
  // R10: the transmit-done cause rises only after an engine completion
  a_r10_tx_cause_src: assert property (@(posedge clk) disable iff (rst)
    $rose(cause[IRQ_TX]) |-> $past(tx_done));
endmodule

// File: tb/pkt_mailbox_tb_top.sv
module pkt_mailbox_tb_top;
  import mbx_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic host_rvalid, irq;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1, tx_err_in = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0, rx_crc_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic stall_mode = 1'b0, hold_mac = 1'b0;

  int checks = 0, errors = 0;
  logic [7:0] cap [64];
  logic       cap_last [64];
  int cap_n = 0;

  always #5 clk = ~clk;

  pkt_mailbox dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .irq(irq), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_err_in(tx_err_in), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .rx_crc_err(rx_crc_err));

  always @(negedge clk) tx_ready <= hold_mac ? 1'b0 : (stall_mode ? ~tx_ready : 1'b1);

  always @(posedge clk) if (tx_valid && tx_ready && cap_n < 64) begin
    cap[cap_n] = tx_data; cap_last[cap_n] = tx_last; cap_n = cap_n + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
    if (!host_rvalid) begin checks++; errors++; $display("FAIL R12: rvalid missing"); end
  endtask

  task automatic wait_tx_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(A_TX_CTL, v);
      if (!v[B_RDY]) return;
    end
    chk("R3 timeout", 32'h1, 32'h0);
  endtask

  task automatic send_rx(input int n, input logic [7:0] b0, input logic e, input logic c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b0 + 8'(i); rx_last = (i == n-1);
      rx_err = e; rx_crc_err = c;
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; rx_crc_err = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_TX_CTL, v);    chk("R1 tx ctl", v, 0);
    rd(A_RX_CTL, v);    chk("R1 rx ctl", v, 0);
    rd(A_IRQ_EN, v);    chk("R1 irq en", v, 0);
    rd(A_IRQ_CAUSE, v); chk("R1 cause", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
  endtask

  task automatic t_tx_basic();
    logic [31:0] v;
    wr(A_IRQ_EN, 32'h2);
    stall_mode = 1'b1; cap_n = 0;
    wr(A_TX_WIN, 32'h10111213);
    wr(A_TX_WIN, 32'h14151617);
    wr(A_TX_CTL, 32'h0000_8007);
    wait_tx_idle();
    stall_mode = 1'b0;
    chk("R2 byte count", cap_n, 7);
    for (int i = 0; i < 7; i++) begin
      chk("R2 byte order", cap[i], 8'h10 + 8'(i));
      chk("R2 last flag", cap_last[i], (i == 6));
    end
    rd(A_TX_CTL, v);    chk("R3 ctl after done", v, 32'h0000_0007);
    rd(A_IRQ_CAUSE, v); chk("R10 tx cause", v, 32'h2);
    chk("R10 irq high", irq, 1);
    wr(A_IRQ_CAUSE, 32'h2);
    @(negedge clk);
    chk("R10 irq cleared", irq, 0);
    rd(A_IRQ_CAUSE, v); chk("R10 cause w1c", v, 0);
  endtask

  task automatic t_tx_err_and_zero();
    logic [31:0] v;
    cap_n = 0; tx_err_in = 1'b1;
    wr(A_TX_WIN, 32'hCAFE0000);
    wr(A_TX_CTL, 32'h0000_8002);
    wait_tx_idle();
    tx_err_in = 1'b0;
    rd(A_TX_CTL, v); chk("R3 tx error flag", v, 32'h0000_4002);
    cap_n = 0;
    wr(A_TX_CTL, 32'h0000_8000);
    repeat (3) @(negedge clk);
    rd(A_TX_CTL, v);    chk("R5 zero length ctl", v, 0);
    chk("R5 no bytes", cap_n, 0);
    rd(A_IRQ_CAUSE, v); chk("R5 done cause", v, 32'h2);
    wr(A_IRQ_CAUSE, 32'h3);
  endtask

  task automatic t_tx_busy();
    logic [31:0] v;
    cap_n = 0; hold_mac = 1'b1;
    wr(A_TX_WIN, 32'hAABBCCDD);
    wr(A_TX_CTL, 32'h0000_8004);
    wr(A_TX_WIN, 32'h11111111);
    wr(A_TX_CTL, 32'h0000_8003);
    rd(A_TX_CTL, v); chk("R4 ctl unchanged while busy", v, 32'h0000_8004);
    hold_mac = 1'b0;
    wait_tx_idle();
    chk("R4 byte count", cap_n, 4);
    chk("R11 pointer restart b0", cap[0], 8'hAA);
    chk("R4 window ignored b3", cap[3], 8'hDD);
    rd(A_TX_WIN, v); chk("R12 tx window reads zero", v, 0);
    wr(A_IRQ_CAUSE, 32'h3);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    wr(A_IRQ_EN, 32'h1);
    send_rx(6, 8'hA0, 1'b0, 1'b1);
    rd(A_RX_CTL, v);    chk("R6 R7 rx ctl", v, 32'h0000_A006);
    rd(A_IRQ_CAUSE, v); chk("R10 rx cause", v, 32'h1);
    chk("R10 rx irq", irq, 1);
    rd(A_RX_WIN, v);    chk("R6 word0", v, 32'hA0A1A2A3);
    rd(A_RX_WIN, v);    chk("R6 word1 padded", v, 32'hA4A5_0000);
    send_rx(3, 8'h11, 1'b1, 1'b0);
    rd(A_RX_CTL, v);    chk("R8 drop keeps ctl, sets ovf", v, 32'h0000_B006);
    wr(A_RX_CTL, 32'h0);
    rd(A_RX_CTL, v);    chk("R8 ovf sticky after release", v, 32'h0000_3006);
    rd(A_RX_WIN, v);    chk("R11 R8 buffer intact at word0", v, 32'hA0A1A2A3);
    wr(A_RX_CTL, 32'h0000_1000);
    rd(A_RX_CTL, v);    chk("R8 ovf cleared by w1", v, 32'h0000_2006);
    wr(A_RX_CTL, 32'h0000_8000);
    rd(A_RX_CTL, v);    chk("R9 sw cannot set ready", v[B_RDY], 0);
    send_rx(5, 8'h50, 1'b1, 1'b0);
    rd(A_RX_CTL, v);    chk("R7 rx error flag", v, 32'h0000_C005);
    rd(A_RX_WIN, v);    chk("R6 second frame word0", v, 32'h50515253);
    wr(A_IRQ_CAUSE, 32'h1);
    @(negedge clk);
    chk("R10 rx irq cleared", irq, 0);
    rd(12'h7FC, v);     chk("R12 unmapped zero", v, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_basic();
        t_tx_err_and_zero();
        t_tx_busy();
        t_rx();
      end
      begin
        repeat (100000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule